// File: doc/BRIEF.md
# Pseudo-random logic self-test engine

This engine tests one small combinational block that sits next to it. A start pulse launches a run. For seven clock cycles the engine drives the block's inputs from a 3-bit pseudo-random pattern generator, a shift register fed back through an XOR of its own bits. In the same cycles it folds every response word the block returns into a signature register. When the run ends, the engine compares the compacted signature with an expected value supplied on its pins. It then raises done, together with a pass flag that holds the result of that comparison.

A matching signature shows that the block is fault-free with high probability. It is not a proof: different faults can leave the same signature. The engine always drives a pattern and accepts the response in the same cycle, so there is no back-pressure. The block under test must settle combinationally within one clock period, and stimulus and response carry no valid/ready handshake. The run length equals one full period of the generator, and the generator ends the run back on its seed.

Top module: `prbist_engine`

## Requirements
- R1: After reset, done, pass and the signature are all 0, and the stimulus output is 111.
- R2: Once a start is accepted at a clock edge, the stimulus holds 111 in the following cycle. It then takes the values 110, 101, 010, 100, 001 and 011, one per cycle, written with bit 2 on the left.
- R3: An accepted start clears the signature to 0. During each of the seven run cycles, the next signature is {sig[1:0], sig[2]^sig[0]} XOR resp, where resp is sampled in the same cycle as the stimulus.
- R4: Done is 0 during the seven run cycles. It rises in the cycle after the seventh step and stays high until the next accepted start.
- R5: Pass is 1 only while done is high, and only if the final signature equals exp_sig as sampled at the last step.
- R6: A start asserted during a run is ignored. The stimulus sequence, the signature and the moment done rises are all unchanged.
- R7: A start given while done is high begins a new run. In the next cycle done and pass are 0, the signature is 0 and the stimulus is 111.
- R8: While done is high, a change on exp_sig does not change pass.
- R9: The stimulus output is never 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when no run is in progress |
| exp_sig | input | 3 | Expected final signature |
| stim | output | 3 | Pattern driven to the block under test |
| resp | input | 3 | Response word of the block under test |
| done | output | 1 | Run complete, result valid |
| pass | output | 1 | Final signature matched exp_sig |
| sig | output | 3 | Current signature register |

## Verification
The situation hardest to reach from the ports is a start pulse that lands in the middle of a run. It must leave both the pattern ordering and the final signature untouched. The stimulus produces it by pulsing start three cycles after an accepted start, while the scoreboard keeps comparing every pattern against the expected sequence. The bench also swaps in a faulty model of the block and supplies a deliberately wrong expected value. This shows that pass depends on the compacted signature alone.

// File: rtl/prbist_pkg.sv
package prbist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RUN    = 2'd1,
    PH_FINISH = 2'd2
  } phase_t;
endpackage

// File: rtl/prs_gen.sv
module prs_gen #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_en,
  input  logic         step_en,
  output logic [W-1:0] pattern
);
  localparam logic [W-1:0] SEED = {W{1'b1}};

  logic [W-1:0] state_q;
  logic         fb;

  assign fb = state_q[W-1] ^ state_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (seed_en) begin
      state_q <= SEED;
    end else if (step_en) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end

  assign pattern = state_q;
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_en,
  input  logic         fold_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] value,
  output logic [W-1:0] value_next
);
  logic [W-1:0] acc_q;

  assign value_next = {acc_q[W-2:0], acc_q[W-1] ^ acc_q[0]} ^ word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear_en) begin
      acc_q <= '0;
    end else if (fold_en) begin
      acc_q <= value_next;
    end
  end

  assign value = acc_q;
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import prbist_pkg::*;
#(
  parameter int STEPS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic advance,
  output logic capture,
  output logic running,
  output logic finished,
  output logic last_step
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;

  assign running   = (phase_q == PH_RUN);
  assign finished  = (phase_q == PH_FINISH);
  assign last_step = running && (cnt_q == LAST);
  assign load      = start && !running;
  assign advance   = running;
  assign capture   = last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (load) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else if (running) begin
      if (cnt_q == LAST) begin
        phase_q <= PH_FINISH;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prbist_engine.sv
module prbist_engine #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] exp_sig,
  output logic [W-1:0] stim,
  input  logic [W-1:0] resp,
  output logic         done,
  output logic         pass,
  output logic [W-1:0] sig
);
  localparam int STEPS = (1 << W) - 1;

  logic         load, advance, capture, running, finished, last_step;
  logic [W-1:0] sig_next;
  logic         pass_q;

  bist_seq #(.STEPS(STEPS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .advance(advance), .capture(capture),
    .running(running), .finished(finished), .last_step(last_step)
  );

  prs_gen #(.W(W)) gen_i (
    .clk(clk), .rst_n(rst_n), .seed_en(load), .step_en(advance),
    .pattern(stim)
  );

  sig_compactor #(.W(W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clear_en(load), .fold_en(advance),
    .word(resp), .value(sig), .value_next(sig_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
    end else if (load) begin
      pass_q <= 1'b0;
    end else if (capture) begin
      pass_q <= (sig_next == exp_sig);
    end
  end

  assign done = finished;
  assign pass = pass_q && finished;
endmodule

// File: rtl/prbist_engine_chk.sv
module prbist_engine_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] exp_sig,
  input logic [W-1:0] stim,
  input logic [W-1:0] sig,
  input logic         done,
  input logic         pass,
  input logic         running,
  input logic         last_step
);
  AST_STIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stim != '0); // R9
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done); // R5
  AST_DONE_LOW_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !done); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R4
  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !last_step) |=> running); // R6
  AST_START_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> (stim == {W{1'b1}} && sig == '0 && !done)); // R7
  AST_PASS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(pass)); // R8
endmodule

bind prbist_engine prbist_engine_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .exp_sig(exp_sig),
  .stim(stim), .sig(sig), .done(done), .pass(pass),
  .running(running), .last_step(last_step)
);

// File: tb/prbist_engine_tb_top.sv
`timescale 1ns/1ps
module prbist_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] exp_sig = 3'b000;
  logic [2:0] stim;
  logic [2:0] resp;
  logic       done, pass;
  logic [2:0] sig;
  bit         faulty = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [2:0] stim_q[$];

  always #5 clk = ~clk;

  prbist_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_sig(exp_sig),
    .stim(stim), .resp(resp), .done(done), .pass(pass), .sig(sig)
  );

  function automatic logic [2:0] cut(input logic [2:0] s, input bit bad);
    logic [2:0] r;
    r = {s[2] ^ s[1], s[1] & s[0], s[2] | s[0]};
    if (bad) r[0] = 1'b0;
    return r;
  endfunction

  always_comb resp = cut(stim, faulty);

  function automatic logic [2:0] seq_at(input int k);
    case (k)
      0: return 3'b111; 1: return 3'b110; 2: return 3'b101;
      3: return 3'b010; 4: return 3'b100; 5: return 3'b001;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] model_sig(input bit bad);
    logic [2:0] s;
    s = 3'b000;
    for (int k = 0; k < 7; k++) s = {s[1:0], s[2] ^ s[0]} ^ cut(seq_at(k), bad);
    return s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (stim_q.size() > 0) begin
        logic [2:0] e;
        e = stim_q.pop_front();
        chk("R2 stimulus order", {5'd0, stim}, {5'd0, e});
        chk("R4 done low in run", {7'd0, done}, 8'd0);
      end
    end
  end

  task automatic run_test(input bit bad, input logic [2:0] expv, input bit poke);
    logic [2:0] want;
    want = model_sig(bad);
    @(negedge clk);
    for (int k = 0; k < 7; k++) stim_q.push_back(seq_at(k));
    faulty  = bad;
    exp_sig = expv;
    start   = 1'b1;
    @(posedge clk);
    #2;
    chk("R7 sig cleared on start", {5'd0, sig}, 8'd0);
    chk("R7 pass cleared on start", {7'd0, pass}, 8'd0);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (stim_q.size() == 0);
    @(posedge clk);
    #2;
    chk("R4 done after seven steps", {7'd0, done}, 8'd1);
    chk(poke ? "R6 signature after ignored start" : "R3 final signature",
        {5'd0, sig}, {5'd0, want});
    chk("R5 pass result", {7'd0, pass}, {7'd0, (want == expv)});
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic p;
    repeat (3) @(negedge clk);
    chk("R1 done reset", {7'd0, done}, 8'd0);
    chk("R1 pass reset", {7'd0, pass}, 8'd0);
    chk("R1 sig reset", {5'd0, sig}, 8'd0);
    chk("R1 stim reset", {5'd0, stim}, 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle without start", {7'd0, done}, 8'd0);

    run_test(1'b0, model_sig(1'b0), 1'b0);
    run_test(1'b0, model_sig(1'b0) ^ 3'b100, 1'b0);
    run_test(1'b1, model_sig(1'b0), 1'b0);
    run_test(1'b0, model_sig(1'b0), 1'b1);

    p = pass;
    @(negedge clk);
    exp_sig = ~exp_sig;
    repeat (3) @(negedge clk);
    chk("R8 pass ignores exp_sig", {7'd0, pass}, {7'd0, p});
    chk("R4 done held", {7'd0, done}, 8'd1);
    chk("R9 idle stim nonzero", {7'd0, (stim != 3'b000)}, 8'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule